// File: doc/BRIEF.md
# Type-C lane-mux switch sequencer

This block takes a mode-change request written by software and reconfigures a Type-C lane crossbar shared by a USB SuperSpeed controller and a DisplayPort controller, without cutting lanes that are still active. A request holds a mux mode, a connector orientation, a low-power flag and a valid strobe. Once the block accepts a request, it asks both controllers to let go of their lanes. It then waits until every lane in use by the crossbar's present mode has reached a deep enough power state, and until any enabled controller acknowledge has arrived.

When the lanes are ready, the block drives the new crossbar inputs: mode, flip and disable. It can wrap that change in a transient safe state. A low-power request disables the crossbar instead of switching it. If the lanes never become ready, a prescaled timeout abandons the request and leaves the crossbar as it was. Either outcome is reported by a one-cycle event pulse.

The configuration inputs (power-state relaxations, handshake enables, auto-safe, auto-block, timeout value) are read live. They are expected to stay steady while a request is in flight.

Top module: `tcs_lane_switch_seq`

## Requirements
- R1: After reset the crossbar mode is 00 and flip and disable are 0. Both release requests, the block-SS output, both events, busy and the pending bit are all 0.
- R2: A write with the valid bit set, made while idle, raises req_pending one cycle later. On the next clock, hardware clears req_pending, busy rises, and both release requests (usb_rxdet_dis, dp_dis) assert.
- R3: Mux mode encoding is 00 no connection, 01 USB only, 10 four DP lanes, 11 USB plus DP lanes 0 and 1. The lanes checked before a switch are those used by the crossbar's present mode.
- R4: Each lane state is a 2-bit code: P3 = 3 and P2 = 2. DP lane i sits at dp_tx_ps bits [2i+1:2i]. A lane counts as ready at P3. It also counts as ready at P2 when usb_p2_ok (for both USB lanes) or dp_p2_ok (for DP lanes) is set. The switch waits for every checked lane.
- R5: With usb_hs_en set, a present USB mode also needs usb_rxdet_ack before switching. With dp_hs_en set, a present DP mode also needs dp_dis_ack.
- R6: With auto_safe_en set and no low-power request, the ready clock edge raises xbar_disable. The next edge applies the new mode and flip. The edge after that clears xbar_disable, and evt_done pulses one cycle later.
- R7: With auto_safe_en clear, the ready edge applies mode and flip with xbar_disable 0, and evt_done pulses on the next cycle.
- R8: A low-power request sets xbar_disable to 1 and leaves mode and flip unchanged, then reports evt_done.
- R9: A programmed timeout value N (N > 0) gives 256·N cycles of waiting. If the lanes are still not ready after that, evt_timeout pulses on the following edge, the releases drop and the crossbar is unchanged. N = 0 never times out. evt_done and evt_timeout never pulse together.
- R10: The xbar_flip output is the latched orientation (0 normal, 1 flipped) XOR flip_invert.
- R11: When a request is accepted, block_ss takes a new value and holds it until the next accepted request. It becomes 1 when auto_block_en[0] is set and the request leaves mode 01, or when auto_block_en[1] is set and the request leaves mode 11. Otherwise it becomes 0.
- R12: Valid writes made while a request is pending or in progress are ignored. The fields latched at acceptance drive the whole sequence.
- R13: evt_done is a single-cycle pulse, and both release requests drop on the cycle it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_wr | input | 1 | Request register write strobe |
| req_valid | input | 1 | Valid bit of the written request |
| req_mode | input | 2 | Requested mux mode |
| req_orient | input | 1 | Requested orientation |
| req_lowpwr | input | 1 | Requested low-power safe state |
| flip_invert | input | 1 | Inverts the meaning of orientation |
| usb_p2_ok | input | 1 | Accept P2 on USB lanes |
| dp_p2_ok | input | 1 | Accept P2 on DP lanes |
| usb_hs_en | input | 1 | Require USB release acknowledge |
| dp_hs_en | input | 1 | Require DP release acknowledge |
| auto_safe_en | input | 1 | Wrap switch in transient disable |
| auto_block_en | input | 2 | Auto block-SS on leaving 01 (bit 0) or 11 (bit 1) |
| timeout_val | input | TMO_BITS | Timeout in units of 256 cycles, 0 = none |
| usb_tx_ps | input | 2 | USB Tx lane power state |
| usb_rx_ps | input | 2 | USB Rx lane power state |
| dp_tx_ps | input | 2·DP_LANES | DP Tx lane power states |
| usb_rxdet_ack | input | 1 | USB controller release acknowledge |
| dp_dis_ack | input | 1 | DP controller release acknowledge |
| req_pending | output | 1 | Valid bit readback, auto-cleared |
| busy | output | 1 | A request is in progress |
| usb_rxdet_dis | output | 1 | Release request to USB controller |
| dp_dis | output | 1 | Release request to DP controller |
| block_ss | output | 1 | Block SuperSpeed operation |
| xbar_mode | output | 2 | Crossbar connection mode |
| xbar_flip | output | 1 | Crossbar flip |
| xbar_disable | output | 1 | Crossbar disable / safe state |
| evt_done | output | 1 | Completion event pulse |
| evt_timeout | output | 1 | Timeout event pulse |

## Verification
Requests are issued in a chain that walks the crossbar through none, USB, four-lane DP and USB plus DP. This matters because each request's readiness depends on the mode left by the one before. Lanes are held at P0, then released to P2 or P3, and individual DP lanes are left lagging. These cases tell apart a correct set of checked lanes from one that waits on too few or too many lanes, and show whether the P2 relaxation and the acknowledge handshakes are honoured. Further requests cover the auto-safe and direct switch orderings, the low-power path, a timeout, a write made while busy, and the flip inversion. A cycle-accurate behavioural model catches any change in event or disable timing.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
   localparam int PS_W = 2;

   typedef enum logic [1:0] {
      MUX_NONE   = 2'b00,
      MUX_USB    = 2'b01,
      MUX_DP_ALL = 2'b10,
      MUX_USB_DP = 2'b11
   } mux_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_SWAP,
      ST_UNSAFE,
      ST_FINISH
   } seq_state_e;

   typedef struct packed {
      mux_mode_e mode;
      logic      orient;
      logic      lowpwr;
   } switch_req_t;

   function automatic logic lane_parked(input logic [PS_W-1:0] ps, input logic p2_ok);
      return (ps == 2'd3) || (p2_ok && (ps == 2'd2));
   endfunction

   function automatic logic mode_has_usb(input mux_mode_e m);
      return (m == MUX_USB) || (m == MUX_USB_DP);
   endfunction

   function automatic logic mode_has_dp(input mux_mode_e m);
      return (m == MUX_DP_ALL) || (m == MUX_USB_DP);
   endfunction
endpackage

// File: rtl/tcs_req_capture.sv
module tcs_req_capture
   import tcs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_stb,
   input  logic        wr_valid,
   input  logic [1:0]  wr_mode,
   input  logic        wr_orient,
   input  logic        wr_lowpwr,
   input  logic        seq_idle,
   output logic        pending,
   output switch_req_t act
);
   logic accept;

   // a request is taken only from an idle sequencer with nothing queued
   assign accept = wr_stb && wr_valid && seq_idle && !pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         act     <= '{mode: MUX_NONE, orient: 1'b0, lowpwr: 1'b0};
      end else if (pending) begin
         pending <= 1'b0;
      end else if (accept) begin
         pending    <= 1'b1;
         act.mode   <= mux_mode_e'(wr_mode);
         act.orient <= wr_orient;
         act.lowpwr <= wr_lowpwr;
      end
   end

   AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      pending |=> !pending); // R2
endmodule

// File: rtl/tcs_lane_ready.sv
module tcs_lane_ready
   import tcs_pkg::*;
#(
   parameter int DP_LANES = 4
) (
   input  mux_mode_e                   cur_mode,
   input  logic [PS_W-1:0]             usb_tx_ps,
   input  logic [PS_W-1:0]             usb_rx_ps,
   input  logic [DP_LANES*PS_W-1:0]    dp_tx_ps,
   input  logic                        usb_p2_ok,
   input  logic                        dp_p2_ok,
   input  logic                        usb_hs_en,
   input  logic                        dp_hs_en,
   input  logic                        usb_ack,
   input  logic                        dp_ack,
   output logic                        ready
);
   localparam int HALF = DP_LANES / 2;

   logic [DP_LANES-1:0] lane_ok;
   logic [DP_LANES-1:0] lane_need;
   logic                usb_ok;
   logic                dp_ok;

   for (genvar i = 0; i < DP_LANES; i++) begin : g_dp_lane
      localparam bit LOW_HALF = (i < HALF);
      assign lane_ok[i]   = lane_parked(dp_tx_ps[i*PS_W +: PS_W], dp_p2_ok);
      assign lane_need[i] = (cur_mode == MUX_DP_ALL) ||
                            ((cur_mode == MUX_USB_DP) && LOW_HALF);
   end

   assign usb_ok = !mode_has_usb(cur_mode) ||
                   (lane_parked(usb_tx_ps, usb_p2_ok) &&
                    lane_parked(usb_rx_ps, usb_p2_ok) &&
                    (!usb_hs_en || usb_ack));

   assign dp_ok  = !mode_has_dp(cur_mode) ||
                   ((&(lane_ok | ~lane_need)) && (!dp_hs_en || dp_ack));

   assign ready  = usb_ok && dp_ok;
endmodule

// File: rtl/tcs_timeout.sv
module tcs_timeout #(
   parameter int PRESCALE_BITS = 8,
   parameter int TMO_BITS      = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic [TMO_BITS-1:0] limit,
   output logic                expired
);
   logic                tick;
   logic [TMO_BITS-1:0] units_q;

   if (PRESCALE_BITS > 0) begin : g_pre
      logic [PRESCALE_BITS-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    pre_q <= '0;
         else if (!run) pre_q <= '0;
         else           pre_q <= pre_q + 1'b1;
      end
      assign tick = run && (&pre_q);
   end else begin : g_nopre
      assign tick = run;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         units_q <= '0;
      else if (!run)                      units_q <= '0;
      else if (tick && units_q != limit)  units_q <= units_q + 1'b1;
   end

   assign expired = run && (limit != '0) && (units_q == limit);

   AST_UNITS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (run && limit != '0) |-> (units_q <= limit)); // R9
endmodule

// File: rtl/tcs_switch_fsm.sv
module tcs_switch_fsm
   import tcs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  switch_req_t act,
   input  logic        ready,
   input  logic        expired,
   input  logic        auto_safe_en,
   input  logic [1:0]  auto_block_en,
   output seq_state_e  state,
   output mux_mode_e   xmode,
   output logic        xflip,
   output logic        xdis,
   output logic        usb_rel,
   output logic        dp_rel,
   output logic        blk,
   output logic        done,
   output logic        tmo
);
   logic leave;

   assign leave = (auto_block_en[0] && xmode == MUX_USB    && act.mode != MUX_USB) ||
                  (auto_block_en[1] && xmode == MUX_USB_DP && act.mode != MUX_USB_DP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         xmode   <= MUX_NONE;
         xflip   <= 1'b0;
         xdis    <= 1'b0;
         usb_rel <= 1'b0;
         dp_rel  <= 1'b0;
         blk     <= 1'b0;
         done    <= 1'b0;
         tmo     <= 1'b0;
      end else begin
         done <= 1'b0;
         tmo  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  usb_rel <= 1'b1;
                  dp_rel  <= 1'b1;
                  blk     <= leave;
                  state   <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (ready) begin
                  if (act.lowpwr) begin
                     xdis  <= 1'b1;
                     state <= ST_FINISH;
                  end else if (auto_safe_en) begin
                     xdis  <= 1'b1;
                     state <= ST_SWAP;
                  end else begin
                     xmode <= act.mode;
                     xflip <= act.orient;
                     xdis  <= 1'b0;
                     state <= ST_FINISH;
                  end
               end else if (expired) begin
                  usb_rel <= 1'b0;
                  dp_rel  <= 1'b0;
                  tmo     <= 1'b1;
                  state   <= ST_IDLE;
               end
            end
            ST_SWAP: begin
               xmode <= act.mode;
               xflip <= act.orient;
               state <= ST_UNSAFE;
            end
            ST_UNSAFE: begin
               xdis  <= 1'b0;
               state <= ST_FINISH;
            end
            ST_FINISH: begin
               usb_rel <= 1'b0;
               dp_rel  <= 1'b0;
               done    <= 1'b1;
               state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && tmo)); // R9
   AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R13
   AST_SAFE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SWAP || state == ST_UNSAFE) |-> xdis); // R6
   AST_REL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> (usb_rel && dp_rel)); // R5
   AST_LP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_WAIT && state == ST_FINISH && act.lowpwr) |-> ($stable(xmode) && xdis)); // R8
endmodule

// File: rtl/tcs_lane_switch_seq.sv
module tcs_lane_switch_seq
   import tcs_pkg::*;
#(
   parameter int DP_LANES      = 4,
   parameter int PRESCALE_BITS = 8,
   parameter int TMO_BITS      = 20
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_wr,
   input  logic                       req_valid,
   input  logic [1:0]                 req_mode,
   input  logic                       req_orient,
   input  logic                       req_lowpwr,
   input  logic                       flip_invert,
   input  logic                       usb_p2_ok,
   input  logic                       dp_p2_ok,
   input  logic                       usb_hs_en,
   input  logic                       dp_hs_en,
   input  logic                       auto_safe_en,
   input  logic [1:0]                 auto_block_en,
   input  logic [TMO_BITS-1:0]        timeout_val,
   input  logic [1:0]                 usb_tx_ps,
   input  logic [1:0]                 usb_rx_ps,
   input  logic [DP_LANES*2-1:0]      dp_tx_ps,
   input  logic                       usb_rxdet_ack,
   input  logic                       dp_dis_ack,
   output logic                       req_pending,
   output logic                       busy,
   output logic                       usb_rxdet_dis,
   output logic                       dp_dis,
   output logic                       block_ss,
   output logic [1:0]                 xbar_mode,
   output logic                       xbar_flip,
   output logic                       xbar_disable,
   output logic                       evt_done,
   output logic                       evt_timeout
);
   if (DP_LANES < 2 || (DP_LANES % 2) != 0) begin : g_bad_lanes
      $error("DP_LANES must be even and at least 2");
   end
   if (TMO_BITS < 1 || TMO_BITS > 32) begin : g_bad_tmo
      $error("TMO_BITS must lie in 1..32");
   end
   if (PRESCALE_BITS < 0 || PRESCALE_BITS > 16) begin : g_bad_pre
      $error("PRESCALE_BITS must lie in 0..16");
   end

   switch_req_t act;
   seq_state_e  state;
   mux_mode_e   xmode;
   logic        ready;
   logic        expired;
   logic        xflip;

   tcs_req_capture u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (req_wr),
      .wr_valid  (req_valid),
      .wr_mode   (req_mode),
      .wr_orient (req_orient),
      .wr_lowpwr (req_lowpwr),
      .seq_idle  (state == ST_IDLE),
      .pending   (req_pending),
      .act       (act)
   );

   tcs_lane_ready #(.DP_LANES(DP_LANES)) u_rdy (
      .cur_mode  (xmode),
      .usb_tx_ps (usb_tx_ps),
      .usb_rx_ps (usb_rx_ps),
      .dp_tx_ps  (dp_tx_ps),
      .usb_p2_ok (usb_p2_ok),
      .dp_p2_ok  (dp_p2_ok),
      .usb_hs_en (usb_hs_en),
      .dp_hs_en  (dp_hs_en),
      .usb_ack   (usb_rxdet_ack),
      .dp_ack    (dp_dis_ack),
      .ready     (ready)
   );

   tcs_timeout #(.PRESCALE_BITS(PRESCALE_BITS), .TMO_BITS(TMO_BITS)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == ST_WAIT),
      .limit   (timeout_val),
      .expired (expired)
   );

   tcs_switch_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (req_pending),
      .act           (act),
      .ready         (ready),
      .expired       (expired),
      .auto_safe_en  (auto_safe_en),
      .auto_block_en (auto_block_en),
      .state         (state),
      .xmode         (xmode),
      .xflip         (xflip),
      .xdis          (xbar_disable),
      .usb_rel       (usb_rxdet_dis),
      .dp_rel        (dp_dis),
      .blk           (block_ss),
      .done          (evt_done),
      .tmo           (evt_timeout)
   );

   assign busy      = (state != ST_IDLE);
   assign xbar_mode = xmode;
   assign xbar_flip = xflip ^ flip_invert;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req_pending) |-> (!usb_rxdet_dis && !dp_dis)); // R13
endmodule

// File: tb/sim_tcs_lane_switch_seq.sv
module sim_tcs_lane_switch_seq;
   localparam int DPL = 4;
   localparam int TB  = 20;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic           rst_n = 1'b0;
   logic           req_wr = 0, req_valid = 0, req_orient = 0, req_lowpwr = 0;
   logic [1:0]     req_mode = 0;
   logic           flip_invert = 0, usb_p2_ok = 0, dp_p2_ok = 0;
   logic           usb_hs_en = 0, dp_hs_en = 0, auto_safe_en = 0;
   logic [1:0]     auto_block_en = 0;
   logic [TB-1:0]  timeout_val = 20'd1000;
   logic [1:0]     usb_tx_ps = 2'd3, usb_rx_ps = 2'd3;
   logic [DPL*2-1:0] dp_tx_ps = '1;
   logic           usb_rxdet_ack = 0, dp_dis_ack = 0;

   logic           req_pending, busy, usb_rxdet_dis, dp_dis, block_ss;
   logic [1:0]     xbar_mode;
   logic           xbar_flip, xbar_disable, evt_done, evt_timeout;

   tcs_lane_switch_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_valid(req_valid),
      .req_mode(req_mode), .req_orient(req_orient), .req_lowpwr(req_lowpwr),
      .flip_invert(flip_invert), .usb_p2_ok(usb_p2_ok), .dp_p2_ok(dp_p2_ok),
      .usb_hs_en(usb_hs_en), .dp_hs_en(dp_hs_en), .auto_safe_en(auto_safe_en),
      .auto_block_en(auto_block_en), .timeout_val(timeout_val),
      .usb_tx_ps(usb_tx_ps), .usb_rx_ps(usb_rx_ps), .dp_tx_ps(dp_tx_ps),
      .usb_rxdet_ack(usb_rxdet_ack), .dp_dis_ack(dp_dis_ack),
      .req_pending(req_pending), .busy(busy), .usb_rxdet_dis(usb_rxdet_dis),
      .dp_dis(dp_dis), .block_ss(block_ss), .xbar_mode(xbar_mode),
      .xbar_flip(xbar_flip), .xbar_disable(xbar_disable),
      .evt_done(evt_done), .evt_timeout(evt_timeout)
   );

   int n_chk = 0, n_fail = 0, n_done = 0, n_tmo = 0, cyc = 0;
   bit finished = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // behavioural reference model
   int m_st, m_wait;
   int m_pend, m_mode, m_or, m_lp;
   int m_xmode, m_xflip, m_xdis, m_urel, m_drel, m_blk, m_done, m_tmo;
   bit m_rdy;

   function automatic bit ps_ok(input logic [1:0] p, input logic p2);
      return (p == 2'd3) || (p2 && p == 2'd2);
   endfunction

   function automatic bit model_ready();
      bit ok = 1;
      if (m_xmode == 1 || m_xmode == 3) begin
         if (!ps_ok(usb_tx_ps, usb_p2_ok) || !ps_ok(usb_rx_ps, usb_p2_ok)) ok = 0;
         if (usb_hs_en && !usb_rxdet_ack) ok = 0;
      end
      if (m_xmode == 2 || m_xmode == 3) begin
         for (int i = 0; i < DPL; i++)
            if (m_xmode == 2 || i < DPL / 2)
               if (!ps_ok(dp_tx_ps[2*i +: 2], dp_p2_ok)) ok = 0;
         if (dp_hs_en && !dp_dis_ack) ok = 0;
      end
      return ok;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_st = 0; m_wait = 0; m_pend = 0; m_mode = 0; m_or = 0; m_lp = 0;
         m_xmode = 0; m_xflip = 0; m_xdis = 0; m_urel = 0; m_drel = 0;
         m_blk = 0; m_done = 0; m_tmo = 0;
      end else begin
         m_rdy  = model_ready();
         m_done = 0;
         m_tmo  = 0;
         case (m_st)
            0: if (m_pend != 0) begin
                  m_pend = 0;
                  m_blk  = ((auto_block_en[0] && m_xmode == 1 && m_mode != 1) ||
                            (auto_block_en[1] && m_xmode == 3 && m_mode != 3)) ? 1 : 0;
                  m_urel = 1; m_drel = 1; m_wait = 0; m_st = 1;
               end else if (req_wr && req_valid) begin
                  m_pend = 1; m_mode = req_mode; m_or = req_orient; m_lp = req_lowpwr;
               end
            1: if (m_rdy) begin
                  if (m_lp != 0) begin m_xdis = 1; m_st = 4; end
                  else if (auto_safe_en) begin m_xdis = 1; m_st = 2; end
                  else begin m_xmode = m_mode; m_xflip = m_or; m_xdis = 0; m_st = 4; end
               end else if (timeout_val != 0 && m_wait == 256 * int'(timeout_val)) begin
                  m_tmo = 1; m_urel = 0; m_drel = 0; m_st = 0;
               end else m_wait++;
            2: begin m_xmode = m_mode; m_xflip = m_or; m_st = 3; end
            3: begin m_xdis = 0; m_st = 4; end
            default: begin m_urel = 0; m_drel = 0; m_done = 1; m_st = 0; end
         endcase
      end
      if (cyc == 150000 && !finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual=%0d expected=0", cyc);
         summary();
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 pending",      int'(req_pending),   m_pend);
         chk("R2 busy",         int'(busy),          (m_st != 0) ? 1 : 0);
         chk("R5 usb release",  int'(usb_rxdet_dis), m_urel);
         chk("R5 dp release",   int'(dp_dis),        m_drel);
         chk("R3 mode",         int'(xbar_mode),     m_xmode);
         chk("R10 flip",        int'(xbar_flip),     m_xflip ^ int'(flip_invert));
         chk("R6 disable",      int'(xbar_disable),  m_xdis);
         chk("R11 block",       int'(block_ss),      m_blk);
         chk("R13 done",        int'(evt_done),      m_done);
         chk("R9 timeout",      int'(evt_timeout),   m_tmo);
         if (evt_done)    n_done++;
         if (evt_timeout) n_tmo++;
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] md, input logic o, input logic lp);
      req_wr = 1; req_valid = 1; req_mode = md; req_orient = o; req_lowpwr = lp;
      tick();
      req_wr = 0; req_valid = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 3000; i++) begin
         if (!busy && !req_pending) break;
         tick();
      end
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R1 reset state
      chk("R1 mode",    int'(xbar_mode), 0);
      chk("R1 disable", int'(xbar_disable), 0);
      chk("R1 release", int'(usb_rxdet_dis | dp_dis | block_ss), 0);
      chk("R1 events",  int'(evt_done | evt_timeout | busy | req_pending), 0);

      // none -> USB, direct switch
      wr(2'b01, 0, 0);
      chk("R2 pending set", int'(req_pending), 1);
      tick();
      chk("R2 pending cleared", int'(req_pending), 0);
      chk("R2 release up", int'(usb_rxdet_dis & dp_dis), 1);
      wait_idle();
      chk("R3 usb mode", int'(xbar_mode), 1);
      chk("R7 disable low", int'(xbar_disable), 0);
      chk("R13 done count", n_done, 1);

      // USB -> DP4 through safe state, lanes held then parked at P2
      usb_tx_ps = 0; usb_rx_ps = 0; auto_safe_en = 1;
      wr(2'b10, 0, 0);
      repeat (20) tick();
      chk("R4 held busy", int'(busy), 1);
      chk("R4 mode unchanged", int'(xbar_mode), 1);
      usb_p2_ok = 1; usb_tx_ps = 2; usb_rx_ps = 2;
      wait_idle();
      chk("R6 dp4 mode", int'(xbar_mode), 2);
      chk("R6 disable cleared", int'(xbar_disable), 0);

      // DP4 -> USB+DP flipped, DP ack and last lane gating, busy write ignored
      dp_tx_ps = 8'h3F; dp_hs_en = 1; dp_dis_ack = 0;
      wr(2'b11, 1, 0);
      repeat (10) tick();
      chk("R5 waits ack", int'(busy), 1);
      wr(2'b00, 0, 0);
      chk("R12 busy write ignored", int'(req_pending), 0);
      dp_dis_ack = 1;
      repeat (10) tick();
      chk("R4 lane3 gates", int'(busy), 1);
      dp_tx_ps = 8'hFF;
      wait_idle();
      chk("R12 latched mode", int'(xbar_mode), 3);
      chk("R10 flipped", int'(xbar_flip), 1);
      flip_invert = 1;
      tick();
      chk("R10 inverted", int'(xbar_flip), 0);
      flip_invert = 0;

      // timeout while leaving USB+DP with auto block
      auto_block_en = 2'b10; timeout_val = 1; usb_p2_ok = 0; usb_tx_ps = 0; usb_rx_ps = 0;
      wr(2'b01, 0, 0);
      tick();
      chk("R11 block set", int'(block_ss), 1);
      wait_idle();
      chk("R9 timeout seen", n_tmo, 1);
      chk("R9 mode kept", int'(xbar_mode), 3);
      chk("R9 release dropped", int'(usb_rxdet_dis | dp_dis), 0);

      // low power
      usb_tx_ps = 3; usb_rx_ps = 3; timeout_val = 1000;
      wr(2'b00, 0, 1);
      wait_idle();
      chk("R8 disabled", int'(xbar_disable), 1);
      chk("R8 mode kept", int'(xbar_mode), 3);

      // direct switch back to USB
      auto_safe_en = 0; auto_block_en = 0;
      wr(2'b01, 1, 0);
      wait_idle();
      chk("R7 usb mode", int'(xbar_mode), 1);
      chk("R7 enabled", int'(xbar_disable), 0);
      chk("R11 block cleared", int'(block_ss), 0);
      chk("R13 done total", n_done, 5);
      repeat (3) tick();
      if (!finished) begin
         finished = 1;
         summary();
      end
   end
endmodule